// File: doc/BRIEF.md
# RV32I Subset Instruction Decoder

This block is purely combinational. It takes one 32-bit RISC-V instruction word and produces the record the execute stage consumes. The record holds an instruction class, an ALU operation, a branch comparison, up to three register indices each with a valid flag, and an optional sign-extended immediate. It is meant to sit between instruction fetch and the register-file read. Downstream logic never has to look at raw opcode bits. It uses the valid flags to decide which operands to read and whether a write-back happens.

Nine major opcodes are recognised: the register ALU group, the immediate ALU group, LUI, AUIPC, JAL, JALR, conditional branches, and word loads and stores. Every other word, including branch and memory encodings whose funct3 is not in the supported set, decodes as Unsupported. An Unsupported record has no register or immediate operands. LUI is folded into an ordinary ALU add whose first source is register 0. This lets execute treat it like any other immediate ALU operation.

Top module: `rvdec_top`

## Requirements
- R1: Register index fields are taken from fixed bit positions: opcode [6:0], destination [11:7], funct3 [14:12], source 1 [19:15], source 2 [24:20].
- R2: Major opcode 0110011 decodes to class Alu (class codes: Unsupported 0, Alu 1, Ld 2, St 3, J 4, Jr 5, Br 6, Auipc 7). It has valid destination, source 1 and source 2 and no immediate. funct3 selects the ALU code, and bit 30 picks Sub over Add and Sra over Srl. The ALU codes are Add 0, Sub 1, And 2, Or 3, Xor 4, Slt 5, Sltu 6, Sll 7, Sra 8, Srl 9. The funct3 mapping is 000 add/sub, 001 sll, 010 slt, 011 sltu, 100 xor, 101 shift right, 110 or, 111 and.
- R3: Major opcode 0010011 decodes to class Alu with a valid destination and source 1, no source 2, and the sign-extended I-immediate (bits [31:20]). It uses the same funct3 mapping as R2, except that funct3 000 is always Add. For funct3 101, bit 30 picks Sra over Srl.
- R4: Major opcode 0110111 (LUI) decodes to class Alu with ALU code Add. Source 1 is valid with index 0, source 2 is invalid, the destination is valid, and the immediate is the U-immediate (bits [31:12] above twelve zero bits).
- R5: Major opcode 0010111 (AUIPC) decodes to class Auipc with a valid destination, no register sources, and the U-immediate.
- R6: Major opcode 1101111 (JAL) decodes to class J with branch code AT, a valid destination and no register sources. The branch codes are Eq 0, Neq 1, Lt 2, Ltu 3, Ge 4, Geu 5, AT 6, NT 7. The immediate is the J-immediate: sign, bits [19:12], bit 20, bits [30:21], then a zero, covering a byte offset range of plus or minus 1 MB.
- R7: Major opcode 1100111 (JALR) decodes to class Jr with branch code AT, a valid destination, valid source 1, no source 2, and the I-immediate.
- R8: Major opcode 1100011 decodes to class Br with no destination and with both sources valid. The B-immediate is sign, bit 7, bits [30:25], bits [11:8], then a zero, covering plus or minus 4 KB. The branch code follows funct3: 000 Eq, 001 Neq, 100 Lt, 101 Ge, 110 Ltu, 111 Geu.
- R9: A branch with funct3 010 or 011 decodes as Unsupported.
- R10: Major opcode 0000011 with funct3 010 decodes to class Ld with Add, a valid destination, source 1 and the I-immediate. Major opcode 0100011 with funct3 010 decodes to class St with Add, both sources, no destination, and the S-immediate (bits [31:25] above bits [11:7], sign-extended).
- R11: A load or store whose funct3 is not 010 decodes as Unsupported.
- R12: Any other major opcode decodes as Unsupported, with the destination, both sources and the immediate all invalid, and branch code NT.
- R13: Every class other than J, Jr and Br carries branch code NT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| cls_o | output | 3 | Instruction class code |
| alu_fn_o | output | 4 | ALU operation code |
| br_fn_o | output | 3 | Branch comparison code |
| rd_vld_o | output | 1 | Destination register is written |
| rd_idx_o | output | 5 | Destination register index |
| rs1_vld_o | output | 1 | Source 1 is read |
| rs1_idx_o | output | 5 | Source 1 index (0 for LUI) |
| rs2_vld_o | output | 1 | Source 2 is read |
| rs2_idx_o | output | 5 | Source 2 index |
| imm_vld_o | output | 1 | Immediate operand is present |
| imm_o | output | XLEN | Sign-extended immediate |

## Verification
The bench builds each instruction from an intended offset and compares the decoded immediate with that offset. A swapped or misplaced bit in the B or J scramble would give wrong extreme offsets such as -4096 or +1048574, and a missing sign extension would make negative offsets positive. Bit 30 is set on an ADDI, which catches a decoder that wrongly turns it into Sub. SRAI is also checked, where the immediate keeps bit 10. The funct3 gaps in the branch group and the non-word loads and stores are driven, since a decoder that only checked the opcode would report them as valid Br, Ld or St records. LUI is checked for the forced register-0 source, which a design that copied bits [19:15] would get wrong.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;

  localparam int unsigned ILEN = 32;
  localparam int unsigned RIDX = 5;

  typedef enum logic [2:0] {
    CLS_UNSUP  = 3'd0,
    CLS_ALU    = 3'd1,
    CLS_LOAD   = 3'd2,
    CLS_STORE  = 3'd3,
    CLS_JUMP   = 3'd4,
    CLS_JUMPR  = 3'd5,
    CLS_BRANCH = 3'd6,
    CLS_AUIPC  = 3'd7
  } op_class_e;

  typedef enum logic [3:0] {
    ALU_ADD  = 4'd0,
    ALU_SUB  = 4'd1,
    ALU_AND  = 4'd2,
    ALU_OR   = 4'd3,
    ALU_XOR  = 4'd4,
    ALU_SLT  = 4'd5,
    ALU_SLTU = 4'd6,
    ALU_SLL  = 4'd7,
    ALU_SRA  = 4'd8,
    ALU_SRL  = 4'd9
  } alu_fn_e;

  typedef enum logic [2:0] {
    BR_EQ  = 3'd0,
    BR_NE  = 3'd1,
    BR_LT  = 3'd2,
    BR_LTU = 3'd3,
    BR_GE  = 3'd4,
    BR_GEU = 3'd5,
    BR_AT  = 3'd6,
    BR_NT  = 3'd7
  } br_fn_e;

  typedef enum logic [2:0] {
    FMT_NONE = 3'd0,
    FMT_I    = 3'd1,
    FMT_S    = 3'd2,
    FMT_B    = 3'd3,
    FMT_U    = 3'd4,
    FMT_J    = 3'd5
  } imm_fmt_e;

  localparam logic [6:0] OPC_REG    = 7'b0110011;
  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;

  localparam logic [2:0] F3_WORD = 3'b010;

  // funct3 to ALU operation; alt selects the bit-30 variant where one exists
  function automatic alu_fn_e alu_from_f3(input logic [2:0] f3, input logic alt);
    case (f3)
      3'b000:  return alt ? ALU_SUB : ALU_ADD;
      3'b001:  return ALU_SLL;
      3'b010:  return ALU_SLT;
      3'b011:  return ALU_SLTU;
      3'b100:  return ALU_XOR;
      3'b101:  return alt ? ALU_SRA : ALU_SRL;
      3'b110:  return ALU_OR;
      default: return ALU_AND;
    endcase
  endfunction

  // funct3 of a conditional branch; ok is low for the two reserved codes
  function automatic logic br_f3_ok(input logic [2:0] f3);
    return (f3 != 3'b010) && (f3 != 3'b011);
  endfunction

  function automatic br_fn_e br_from_f3(input logic [2:0] f3);
    case (f3)
      3'b000:  return BR_EQ;
      3'b001:  return BR_NE;
      3'b100:  return BR_LT;
      3'b101:  return BR_GE;
      3'b110:  return BR_LTU;
      3'b111:  return BR_GEU;
      default: return BR_NT;
    endcase
  endfunction

endpackage

// File: rtl/rvdec_imm_gen.sv
module rvdec_imm_gen
  import rvdec_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [ILEN-1:0] instr_i,
  input  imm_fmt_e        fmt_i,
  output logic [XLEN-1:0] imm_o,
  output logic            imm_vld_o
);

  function automatic logic [XLEN-1:0] imm_i_f(input logic [ILEN-1:0] w);
    return XLEN'($signed(w[31:20]));
  endfunction

  function automatic logic [XLEN-1:0] imm_s_f(input logic [ILEN-1:0] w);
    return XLEN'($signed({w[31:25], w[11:7]}));
  endfunction

  function automatic logic [XLEN-1:0] imm_b_f(input logic [ILEN-1:0] w);
    return XLEN'($signed({w[31], w[7], w[30:25], w[11:8], 1'b0}));
  endfunction

  function automatic logic [XLEN-1:0] imm_u_f(input logic [ILEN-1:0] w);
    return XLEN'($signed({w[31:12], 12'b0}));
  endfunction

  function automatic logic [XLEN-1:0] imm_j_f(input logic [ILEN-1:0] w);
    return XLEN'($signed({w[31], w[19:12], w[20], w[30:21], 1'b0}));
  endfunction

  always_comb begin
    imm_vld_o = 1'b1;
    unique case (fmt_i)
      FMT_I:   imm_o = imm_i_f(instr_i);
      FMT_S:   imm_o = imm_s_f(instr_i);
      FMT_B:   imm_o = imm_b_f(instr_i);
      FMT_U:   imm_o = imm_u_f(instr_i);
      FMT_J:   imm_o = imm_j_f(instr_i);
      default: begin
        imm_o     = '0;
        imm_vld_o = 1'b0;
      end
    endcase
  end

  // Branch and jump offsets are halfword aligned (R6, R8)
  always_comb begin
    if (fmt_i == FMT_B || fmt_i == FMT_J)
      p_offset_even_r8: assert (imm_o[0] == 1'b0) else $error("odd control offset");
  end

  // Upper immediate leaves the low twelve bits clear (R4, R5)
  always_comb begin
    if (fmt_i == FMT_U)
      p_upper_low_zero_r5: assert (imm_o[11:0] == 12'd0) else $error("U-imm low bits");
  end

endmodule

// File: rtl/rvdec_ctrl.sv
module rvdec_ctrl
  import rvdec_pkg::*;
(
  input  logic [6:0] opcode_i,
  input  logic [2:0] funct3_i,
  input  logic       alt_i,
  output op_class_e  cls_o,
  output alu_fn_e    alu_fn_o,
  output br_fn_e     br_fn_o,
  output imm_fmt_e   fmt_o,
  output logic       rd_vld_o,
  output logic       rs1_vld_o,
  output logic       rs1_zero_o,
  output logic       rs2_vld_o
);

  always_comb begin
    cls_o      = CLS_UNSUP;
    alu_fn_o   = ALU_ADD;
    br_fn_o    = BR_NT;
    fmt_o      = FMT_NONE;
    rd_vld_o   = 1'b0;
    rs1_vld_o  = 1'b0;
    rs1_zero_o = 1'b0;
    rs2_vld_o  = 1'b0;
    case (opcode_i)
      OPC_REG: begin
        cls_o     = CLS_ALU;
        alu_fn_o  = alu_from_f3(funct3_i, alt_i);
        rd_vld_o  = 1'b1;
        rs1_vld_o = 1'b1;
        rs2_vld_o = 1'b1;
      end
      OPC_IMM: begin
        cls_o     = CLS_ALU;
        // only the right shift has a bit-30 variant for immediates
        alu_fn_o  = alu_from_f3(funct3_i, alt_i && (funct3_i == 3'b101));
        fmt_o     = FMT_I;
        rd_vld_o  = 1'b1;
        rs1_vld_o = 1'b1;
      end
      OPC_LUI: begin
        cls_o      = CLS_ALU;
        fmt_o      = FMT_U;
        rd_vld_o   = 1'b1;
        rs1_vld_o  = 1'b1;
        rs1_zero_o = 1'b1;
      end
      OPC_AUIPC: begin
        cls_o    = CLS_AUIPC;
        fmt_o    = FMT_U;
        rd_vld_o = 1'b1;
      end
      OPC_JAL: begin
        cls_o    = CLS_JUMP;
        br_fn_o  = BR_AT;
        fmt_o    = FMT_J;
        rd_vld_o = 1'b1;
      end
      OPC_JALR: begin
        cls_o     = CLS_JUMPR;
        br_fn_o   = BR_AT;
        fmt_o     = FMT_I;
        rd_vld_o  = 1'b1;
        rs1_vld_o = 1'b1;
      end
      OPC_BRANCH: begin
        if (br_f3_ok(funct3_i)) begin
          cls_o     = CLS_BRANCH;
          br_fn_o   = br_from_f3(funct3_i);
          fmt_o     = FMT_B;
          rs1_vld_o = 1'b1;
          rs2_vld_o = 1'b1;
        end
      end
      OPC_LOAD: begin
        if (funct3_i == F3_WORD) begin
          cls_o     = CLS_LOAD;
          fmt_o     = FMT_I;
          rd_vld_o  = 1'b1;
          rs1_vld_o = 1'b1;
        end
      end
      OPC_STORE: begin
        if (funct3_i == F3_WORD) begin
          cls_o     = CLS_STORE;
          fmt_o     = FMT_S;
          rs1_vld_o = 1'b1;
          rs2_vld_o = 1'b1;
        end
      end
      default: ;
    endcase
  end

  // Memory classes only come out of a word-width funct3 (R11)
  always_comb begin
    if (cls_o == CLS_LOAD || cls_o == CLS_STORE)
      p_word_only_r11: assert (funct3_i == F3_WORD) else $error("non-word memory op");
  end

  // Reserved branch funct3 never yields a branch record (R9)
  always_comb begin
    if (cls_o == CLS_BRANCH)
      p_branch_f3_legal_r9: assert (funct3_i != 3'b010 && funct3_i != 3'b011)
        else $error("reserved branch funct3 accepted");
  end

endmodule

// File: rtl/rvdec_top.sv
module rvdec_top
  import rvdec_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [31:0]     instr_i,
  output logic [2:0]      cls_o,
  output logic [3:0]      alu_fn_o,
  output logic [2:0]      br_fn_o,
  output logic            rd_vld_o,
  output logic [4:0]      rd_idx_o,
  output logic            rs1_vld_o,
  output logic [4:0]      rs1_idx_o,
  output logic            rs2_vld_o,
  output logic [4:0]      rs2_idx_o,
  output logic            imm_vld_o,
  output logic [XLEN-1:0] imm_o
);

  // named internal events
  op_class_e cls_w;
  alu_fn_e   alu_w;
  br_fn_e    br_w;
  imm_fmt_e  fmt_w;
  logic      rd_v_w, rs1_v_w, rs1_zero_w, rs2_v_w;

  rvdec_ctrl u_ctrl (
    .opcode_i  (instr_i[6:0]),
    .funct3_i  (instr_i[14:12]),
    .alt_i     (instr_i[30]),
    .cls_o     (cls_w),
    .alu_fn_o  (alu_w),
    .br_fn_o   (br_w),
    .fmt_o     (fmt_w),
    .rd_vld_o  (rd_v_w),
    .rs1_vld_o (rs1_v_w),
    .rs1_zero_o(rs1_zero_w),
    .rs2_vld_o (rs2_v_w)
  );

  rvdec_imm_gen #(.XLEN(XLEN)) u_imm (
    .instr_i  (instr_i),
    .fmt_i    (fmt_w),
    .imm_o    (imm_o),
    .imm_vld_o(imm_vld_o)
  );

  assign cls_o     = cls_w;
  assign alu_fn_o  = alu_w;
  assign br_fn_o   = br_w;
  assign rd_vld_o  = rd_v_w;
  assign rs1_vld_o = rs1_v_w;
  assign rs2_vld_o = rs2_v_w;
  assign rd_idx_o  = instr_i[11:7];
  assign rs1_idx_o = rs1_zero_w ? '0 : instr_i[19:15];
  assign rs2_idx_o = instr_i[24:20];

  // Unsupported records carry no operands at all (R12)
  always_comb begin
    if (cls_w == CLS_UNSUP)
      p_unsup_empty_r12: assert (!rd_v_w && !rs1_v_w && !rs2_v_w && !imm_vld_o && br_w == BR_NT)
        else $error("unsupported record has operands");
  end

  // Stores and branches never write back (R8, R10)
  always_comb begin
    if (cls_w == CLS_STORE || cls_w == CLS_BRANCH)
      p_no_writeback_r10: assert (!rd_v_w) else $error("store/branch with destination");
  end

  // Only control transfers carry a comparison other than NT (R13)
  always_comb begin
    if (cls_w != CLS_JUMP && cls_w != CLS_JUMPR && cls_w != CLS_BRANCH)
      p_never_taken_r13: assert (br_w == BR_NT) else $error("non-control with branch fn");
  end

  // Every supported class except Alu-from-register has an immediate (R3)
  always_comb begin
    if (cls_w != CLS_UNSUP && !rs2_v_w)
      p_imm_replaces_rs2_r3: assert (imm_vld_o) else $error("no second operand");
  end

  // JAL reads no registers (R6)
  always_comb begin
    if (cls_w == CLS_JUMP)
      p_jal_no_src_r6: assert (!rs1_v_w && !rs2_v_w && br_w == BR_AT) else $error("JAL operands");
  end

endmodule

// File: tb/rvdec_top_tb_top.sv
module rvdec_top_tb_top;

  // bench-side encodings (from the requirements)
  localparam logic [2:0] C_UNS = 3'd0, C_ALU = 3'd1, C_LD = 3'd2, C_ST = 3'd3,
                         C_J = 3'd4, C_JR = 3'd5, C_BR = 3'd6, C_AUI = 3'd7;
  localparam logic [3:0] A_ADD = 4'd0, A_SUB = 4'd1, A_AND = 4'd2, A_OR = 4'd3,
                         A_XOR = 4'd4, A_SLT = 4'd5, A_SLTU = 4'd6, A_SLL = 4'd7,
                         A_SRA = 4'd8, A_SRL = 4'd9;
  localparam logic [2:0] B_EQ = 3'd0, B_NE = 3'd1, B_LT = 3'd2, B_LTU = 3'd3,
                         B_GE = 3'd4, B_GEU = 3'd5, B_AT = 3'd6, B_NT = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = 32'd0;
  logic [2:0]  cls;
  logic [3:0]  alu;
  logic [2:0]  br;
  logic        rdv, r1v, r2v, imv;
  logic [4:0]  rd, r1, r2;
  logic [31:0] imm;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rvdec_top dut_i (
    .instr_i(instr), .cls_o(cls), .alu_fn_o(alu), .br_fn_o(br),
    .rd_vld_o(rdv), .rd_idx_o(rd), .rs1_vld_o(r1v), .rs1_idx_o(r1),
    .rs2_vld_o(r2v), .rs2_idx_o(r2), .imm_vld_o(imv), .imm_o(imm)
  );

  function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] s2, s1,
                                        input logic [2:0] f3, input logic [4:0] d, input logic [6:0] op);
    return {f7, s2, s1, f3, d, op};
  endfunction
  function automatic logic [31:0] enc_i(input int v, input logic [4:0] s1, input logic [2:0] f3,
                                        input logic [4:0] d, input logic [6:0] op);
    logic [31:0] x = 32'(v);
    return {x[11:0], s1, f3, d, op};
  endfunction
  function automatic logic [31:0] enc_s(input int v, input logic [4:0] s2, s1, input logic [2:0] f3);
    logic [31:0] x = 32'(v);
    return {x[11:5], s2, s1, f3, x[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] enc_b(input int v, input logic [4:0] s2, s1, input logic [2:0] f3);
    logic [31:0] x = 32'(v);
    return {x[12], x[10:5], s2, s1, f3, x[4:1], x[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] enc_j(input int v, input logic [4:0] d);
    logic [31:0] x = 32'(v);
    return {x[20], x[10:1], x[11], x[19:12], d, 7'b1101111};
  endfunction

  task automatic chk(input string tag, input string fld, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
    end
  endtask

  // apply one word and compare the whole record
  task automatic expect_rec(input string tag, input logic [31:0] w,
                            input logic [2:0] ec, input logic [3:0] ea, input logic [2:0] eb,
                            input logic erdv, input logic [4:0] erd,
                            input logic e1v, input logic [4:0] e1,
                            input logic e2v, input logic [4:0] e2,
                            input logic eiv, input logic [31:0] ei);
    @(negedge clk);
    instr = w;
    #2;
    chk(tag, "class", 32'(cls), 32'(ec));
    chk(tag, "alu", 32'(alu), 32'(ea));
    chk(tag, "br", 32'(br), 32'(eb));
    chk(tag, "rd_vld", 32'(rdv), 32'(erdv));
    chk(tag, "rs1_vld", 32'(r1v), 32'(e1v));
    chk(tag, "rs2_vld", 32'(r2v), 32'(e2v));
    chk(tag, "imm_vld", 32'(imv), 32'(eiv));
    if (erdv) chk(tag, "rd", 32'(rd), 32'(erd));
    if (e1v)  chk(tag, "rs1", 32'(r1), 32'(e1));
    if (e2v)  chk(tag, "rs2", 32'(r2), 32'(e2));
    if (eiv)  chk(tag, "imm", imm, ei);
  endtask

  task automatic t_reset();  // R12: all-zero word is not a supported opcode
    expect_rec("R12 reset", 32'd0, C_UNS, A_ADD, B_NT, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_reg_ops();  // R1 R2
    logic [3:0] exp_a [8] = '{A_ADD, A_SLL, A_SLT, A_SLTU, A_XOR, A_SRL, A_OR, A_AND};
    for (int f = 0; f < 8; f++)
      expect_rec("R2 op", enc_r(7'd0, 5'd21, 5'd10, 3'(f), 5'd31, 7'b0110011),
                 C_ALU, exp_a[f], B_NT, 1, 5'd31, 1, 5'd10, 1, 5'd21, 0, 0);
    expect_rec("R2 sub", enc_r(7'b0100000, 5'd3, 5'd2, 3'b000, 5'd1, 7'b0110011),
               C_ALU, A_SUB, B_NT, 1, 5'd1, 1, 5'd2, 1, 5'd3, 0, 0);
    expect_rec("R2 sra", enc_r(7'b0100000, 5'd7, 5'd6, 3'b101, 5'd5, 7'b0110011),
               C_ALU, A_SRA, B_NT, 1, 5'd5, 1, 5'd6, 1, 5'd7, 0, 0);
  endtask

  task automatic t_imm_ops();  // R3 R13
    expect_rec("R3 addi neg", enc_i(-2048, 5'd4, 3'b000, 5'd9, 7'b0010011),
               C_ALU, A_ADD, B_NT, 1, 5'd9, 1, 5'd4, 0, 0, 1, 32'hFFFF_F800);
    // bit 30 set on an addi must not give Sub
    expect_rec("R3 addi bit30", enc_i(32'h400 | 5, 5'd4, 3'b000, 5'd9, 7'b0010011),
               C_ALU, A_ADD, B_NT, 1, 5'd9, 1, 5'd4, 0, 0, 1, 32'h0000_0405);
    expect_rec("R3 slli", enc_i(13, 5'd8, 3'b001, 5'd2, 7'b0010011),
               C_ALU, A_SLL, B_NT, 1, 5'd2, 1, 5'd8, 0, 0, 1, 32'd13);
    expect_rec("R3 srli", enc_i(31, 5'd8, 3'b101, 5'd2, 7'b0010011),
               C_ALU, A_SRL, B_NT, 1, 5'd2, 1, 5'd8, 0, 0, 1, 32'd31);
    expect_rec("R3 srai", enc_i(32'h400 | 3, 5'd8, 3'b101, 5'd2, 7'b0010011),
               C_ALU, A_SRA, B_NT, 1, 5'd2, 1, 5'd8, 0, 0, 1, 32'h0000_0403);
    expect_rec("R3 andi max", enc_i(2047, 5'd1, 3'b111, 5'd3, 7'b0010011),
               C_ALU, A_AND, B_NT, 1, 5'd3, 1, 5'd1, 0, 0, 1, 32'd2047);
  endtask

  task automatic t_upper();  // R4 R5
    expect_rec("R4 lui", {20'hABCDE, 5'd7, 7'b0110111} | (32'd0),
               C_ALU, A_ADD, B_NT, 1, 5'd7, 1, 5'd0, 0, 0, 1, 32'hABCDE000);
    // rs1 field bits [19:15] are nonzero here (part of the immediate)
    expect_rec("R4 lui rs1 forced", {20'h7FFFF, 5'd12, 7'b0110111},
               C_ALU, A_ADD, B_NT, 1, 5'd12, 1, 5'd0, 0, 0, 1, 32'h7FFFF000);
    expect_rec("R5 auipc", {20'h80001, 5'd30, 7'b0010111},
               C_AUI, A_ADD, B_NT, 1, 5'd30, 0, 0, 0, 0, 1, 32'h80001000);
  endtask

  task automatic t_jumps();  // R6 R7
    expect_rec("R6 jal min", enc_j(-1048576, 5'd1), C_J, A_ADD, B_AT, 1, 5'd1, 0, 0, 0, 0, 1, 32'hFFF0_0000);
    expect_rec("R6 jal max", enc_j(1048574, 5'd1), C_J, A_ADD, B_AT, 1, 5'd1, 0, 0, 0, 0, 1, 32'h000F_FFFE);
    expect_rec("R6 jal mix", enc_j(32'h0005_5AAA, 5'd0), C_J, A_ADD, B_AT, 1, 5'd0, 0, 0, 0, 0, 1, 32'h0005_5AAA);
    expect_rec("R7 jalr", enc_i(-4, 5'd17, 3'b000, 5'd1, 7'b1100111),
               C_JR, A_ADD, B_AT, 1, 5'd1, 1, 5'd17, 0, 0, 1, 32'hFFFF_FFFC);
  endtask

  task automatic t_branches();  // R8
    logic [2:0] f3s [6] = '{3'b000, 3'b001, 3'b100, 3'b101, 3'b110, 3'b111};
    logic [2:0] bfs [6] = '{B_EQ, B_NE, B_LT, B_GE, B_LTU, B_GEU};
    for (int k = 0; k < 6; k++)
      expect_rec("R8 branch", enc_b(-4096, 5'd20, 5'd19, f3s[k]),
                 C_BR, A_ADD, bfs[k], 0, 0, 1, 5'd19, 1, 5'd20, 1, 32'hFFFF_F000);
    expect_rec("R8 br max", enc_b(4094, 5'd2, 5'd1, 3'b000),
               C_BR, A_ADD, B_EQ, 0, 0, 1, 5'd1, 1, 5'd2, 1, 32'h0000_0FFE);
    expect_rec("R8 br bit11", enc_b(32'h800, 5'd2, 5'd1, 3'b001),
               C_BR, A_ADD, B_NE, 0, 0, 1, 5'd1, 1, 5'd2, 1, 32'h0000_0800);
  endtask

  task automatic t_bad_branch();  // R9
    expect_rec("R9 br f3=010", enc_b(8, 5'd2, 5'd1, 3'b010), C_UNS, A_ADD, B_NT, 0, 0, 0, 0, 0, 0, 0, 0);
    expect_rec("R9 br f3=011", enc_b(8, 5'd2, 5'd1, 3'b011), C_UNS, A_ADD, B_NT, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_mem();  // R10 R11
    expect_rec("R10 lw", enc_i(-1, 5'd2, 3'b010, 5'd8, 7'b0000011),
               C_LD, A_ADD, B_NT, 1, 5'd8, 1, 5'd2, 0, 0, 1, 32'hFFFF_FFFF);
    expect_rec("R10 sw", enc_s(1234, 5'd9, 5'd2, 3'b010),
               C_ST, A_ADD, B_NT, 0, 0, 1, 5'd2, 1, 5'd9, 1, 32'd1234);
    expect_rec("R10 sw neg", enc_s(-2048, 5'd9, 5'd2, 3'b010),
               C_ST, A_ADD, B_NT, 0, 0, 1, 5'd2, 1, 5'd9, 1, 32'hFFFF_F800);
    expect_rec("R11 lb", enc_i(4, 5'd2, 3'b000, 5'd8, 7'b0000011), C_UNS, A_ADD, B_NT, 0, 0, 0, 0, 0, 0, 0, 0);
    expect_rec("R11 lhu", enc_i(4, 5'd2, 3'b101, 5'd8, 7'b0000011), C_UNS, A_ADD, B_NT, 0, 0, 0, 0, 0, 0, 0, 0);
    expect_rec("R11 sh", enc_s(4, 5'd9, 5'd2, 3'b001), C_UNS, A_ADD, B_NT, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_unknown();  // R12
    expect_rec("R12 system", 32'h0000_0073, C_UNS, A_ADD, B_NT, 0, 0, 0, 0, 0, 0, 0, 0);
    expect_rec("R12 fence", 32'h0FF0_000F, C_UNS, A_ADD, B_NT, 0, 0, 0, 0, 0, 0, 0, 0);
    expect_rec("R12 ones", 32'hFFFF_FFFF, C_UNS, A_ADD, B_NT, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reg_ops();
    t_imm_ops();
    t_upper();
    t_jumps();
    t_branches();
    t_bad_branch();
    t_mem();
    t_unknown();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: bench did not complete");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule